// File: doc/BRIEF.md
# BCD Calendar Clock with Frozen Read Snapshot

This block keeps wall-clock time and a calendar: seconds, minutes, hours in 24-hour form, a weekday counter, day of month, month and a two-digit year. Every field is held as packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. A one-cycle `tick` pulse, produced elsewhere from a one-pulse-per-second source, advances the time by one second. Carries ripple through the fields in the same cycle. Month lengths and leap Februaries are handled inside the block.

The internal counters advance on every tick without exception. The host reads a separate user copy through a small byte-wide register port. A transfer-enable bit in the control register decides whether that copy follows the counters. Software clears the bit, reads a coherent snapshot across several accesses, and sets the bit again. The copy then catches up with the counters on the next tick. A host write to a time field sets the internal counter and the user copy together. The write does not depend on transfer-enable.

Top module: `rtc_bcd_core`

## Requirements
- R1: After a synchronous reset the user registers read seconds 00, minutes 00, hours 00, weekday 01, day of month 01, month 01 and year 00. The control register reads 0x01.
- R2: Each tick adds one to the seconds in packed BCD. Units 9 wrap to 0 with a carry into the tens digit. Seconds 59 wrap to 00 and add one to the minutes. Minutes follow the same rule and carry into the hours.
- R3: Hours count from 00 to 23. When a carry arrives at hour 23, the hours wrap to 00 and a new day begins.
- R4: At the start of each day the weekday increases by one, and weekday 07 wraps to 01.
- R5: At the start of each day the day of month increases by one. After the last day of the month it returns to 01 and the month advances. Months 01, 03, 05, 07, 08, 10 and 12 have 31 days, and months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year's value is divisible by 4, and 28 days otherwise.
- R6: Month 12 wraps to 01 and adds one to the year. Year 99 wraps to 00.
- R7: The address map is as follows: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year, 7 control. `rd_data` shows the addressed register in the same cycle. Control bit 0 is transfer-enable, and the other control bits read 0.
- R8: While transfer-enable is 0, ticks leave the user registers unchanged, and the internal counters keep advancing.
- R9: While transfer-enable is 1, the user registers equal the advanced internal time in the cycle after each tick. After transfer-enable goes from 0 back to 1, the user registers hold their frozen values until the next tick. That tick brings them fully up to date.
- R10: A write to addresses 0 to 6 loads the same value into the internal field and its user copy. The value reads back in the following cycle, at either value of transfer-enable. Other fields are not touched.
- R11: When a write and a tick fall in the same cycle, the written field takes the written value. Every other field takes its ticked value, and carries are computed from the time held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, one per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |

## Verification
A host write and a tick can fall in the same cycle. The write targets one field while the carry chain is rewriting that field and its neighbours. The bench provokes this by driving `tick` and `wr_en` in the same cycle, with the seconds at 59. It then checks that the written seconds value wins and that the minute carry computed from the old seconds still lands. Both effects are also checked with transfer-enable cleared, where only the written field may change in the user copy.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int RTC_AW     = 3;
    localparam int RTC_DW     = 8;
    localparam int TE_BIT     = 0;

    localparam logic [RTC_AW-1:0] A_SECS  = 3'd0;
    localparam logic [RTC_AW-1:0] A_MINS  = 3'd1;
    localparam logic [RTC_AW-1:0] A_HOURS = 3'd2;
    localparam logic [RTC_AW-1:0] A_WDAY  = 3'd3;
    localparam logic [RTC_AW-1:0] A_MDAY  = 3'd4;
    localparam logic [RTC_AW-1:0] A_MONTH = 3'd5;
    localparam logic [RTC_AW-1:0] A_YEAR  = 3'd6;
    localparam logic [RTC_AW-1:0] A_CTRL  = 3'd7;

    typedef struct packed {
        logic [RTC_DW-1:0] year;
        logic [RTC_DW-1:0] month;
        logic [RTC_DW-1:0] mday;
        logic [RTC_DW-1:0] wday;
        logic [RTC_DW-1:0] hours;
        logic [RTC_DW-1:0] mins;
        logic [RTC_DW-1:0] secs;
    } rtc_time_t;

    localparam rtc_time_t RTC_RESET_TIME =
        {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] b);
        if (b[3:0] == 4'd9) return {b[7:4] + 4'd1, 4'd0};
        return {b[7:4], b[3:0] + 4'd1};
    endfunction

    function automatic logic bcd_leap(input logic [7:0] y);
        logic [7:0] v;
        v = {4'd0, y[7:4]} * 8'd10 + {4'd0, y[3:0]};
        return v[1:0] == 2'b00;
    endfunction

    function automatic logic [7:0] bcd_month_last(input logic [7:0] m,
                                                  input logic [7:0] y);
        case (m)
            8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic [7:0] get_field(input rtc_time_t t,
                                             input logic [RTC_AW-1:0] a);
        case (a)
            A_SECS:  return t.secs;
            A_MINS:  return t.mins;
            A_HOURS: return t.hours;
            A_WDAY:  return t.wday;
            A_MDAY:  return t.mday;
            A_MONTH: return t.month;
            A_YEAR:  return t.year;
            default: return 8'h00;
        endcase
    endfunction

    function automatic rtc_time_t set_field(input rtc_time_t t,
                                            input logic [RTC_AW-1:0] a,
                                            input logic [7:0] d);
        rtc_time_t r;
        r = t;
        case (a)
            A_SECS:  r.secs  = d;
            A_MINS:  r.mins  = d;
            A_HOURS: r.hours = d;
            A_WDAY:  r.wday  = d;
            A_MDAY:  r.mday  = d;
            A_MONTH: r.month = d;
            A_YEAR:  r.year  = d;
            default: r = t;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
#(
    parameter logic [7:0] WDAY_FIRST = 8'h01,
    parameter logic [7:0] WDAY_LAST  = 8'h07
) (
    input  rtc_time_t cur,
    input  logic      step,
    output rtc_time_t nxt
);
    logic c_min, c_hour, c_day, c_mon, c_year;
    logic [7:0] last_day;

    always_comb begin
        last_day = bcd_month_last(cur.month, cur.year);
        c_min    = step   && (cur.secs  == 8'h59);
        c_hour   = c_min  && (cur.mins  == 8'h59);
        c_day    = c_hour && (cur.hours == 8'h23);
        c_mon    = c_day  && (cur.mday  == last_day);
        c_year   = c_mon  && (cur.month == 8'h12);

        nxt = cur;
        if (step)
            nxt.secs  = c_min  ? 8'h00 : bcd_inc(cur.secs);
        if (c_min)
            nxt.mins  = c_hour ? 8'h00 : bcd_inc(cur.mins);
        if (c_hour)
            nxt.hours = c_day  ? 8'h00 : bcd_inc(cur.hours);
        if (c_day) begin
            nxt.wday  = (cur.wday == WDAY_LAST) ? WDAY_FIRST : bcd_inc(cur.wday);
            nxt.mday  = c_mon  ? 8'h01 : bcd_inc(cur.mday);
        end
        if (c_mon)
            nxt.month = c_year ? 8'h01 : bcd_inc(cur.month);
        if (c_year)
            nxt.year  = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
    end
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              te,
    input  logic              tick,
    input  logic              wr_hit,
    input  logic [RTC_AW-1:0] wr_addr,
    input  logic [RTC_DW-1:0] wr_data,
    input  rtc_time_t         live_d,
    output rtc_time_t         user
);
    always_ff @(posedge clk) begin
        if (rst)
            user <= RTC_RESET_TIME;
        else if (te && tick)
            user <= live_d;
        else if (wr_hit)
            user <= set_field(user, wr_addr, wr_data);
    end

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!te && !wr_hit) |=> $stable(user)); // R8
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [RTC_AW-1:0] addr,
    input  logic [RTC_DW-1:0] wr_data,
    output logic [RTC_DW-1:0] rd_data
);
    rtc_time_t live_q, stepped, live_d, user;
    logic      te_q;
    logic      field_wr;

    assign field_wr = wr_en && (addr != A_CTRL);

    rtc_advance u_adv (
        .cur  (live_q),
        .step (tick),
        .nxt  (stepped)
    );

    always_comb begin
        live_d = field_wr ? set_field(stepped, addr, wr_data) : stepped;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= RTC_RESET_TIME;
            te_q   <= 1'b1;
        end else begin
            live_q <= live_d;
            if (wr_en && addr == A_CTRL)
                te_q <= wr_data[TE_BIT];
        end
    end

    rtc_shadow u_shadow (
        .clk     (clk),
        .rst     (rst),
        .te      (te_q),
        .tick    (tick),
        .wr_hit  (field_wr),
        .wr_addr (addr),
        .wr_data (wr_data),
        .live_d  (live_d),
        .user    (user)
    );

    always_comb begin
        if (addr == A_CTRL) begin
            rd_data = '0;
            rd_data[TE_BIT] = te_q;
        end else begin
            rd_data = get_field(user, addr);
        end
    end

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && live_q.secs == 8'h59) |=> (live_q.secs == 8'h00)); // R2

    AST_MIDNIGHT: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && live_q.secs == 8'h59 && live_q.mins == 8'h59
         && live_q.hours == 8'h23) |=> (live_q.hours == 8'h00)); // R3

    AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && live_q.secs == 8'h59 && live_q.mins == 8'h59
         && live_q.hours == 8'h23 && live_q.wday == 8'h07) |=> (live_q.wday == 8'h01)); // R4

    AST_CATCH_UP: assert property (@(posedge clk) disable iff (rst)
        (tick && te_q && !wr_en) |=> (user == live_q)); // R9

    AST_WRITE_SHOWS: assert property (@(posedge clk) disable iff (rst)
        field_wr |=> (get_field(user, $past(addr)) == $past(wr_data))); // R10
endmodule

// File: tb/rtc_bcd_core_test.sv
module rtc_bcd_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int mi[7];
    int mu[7];
    bit te_m;

    rtc_bcd_core uut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    function automatic int to_bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic model_tick();
        mi[0]++;
        if (mi[0] == 60) begin
            mi[0] = 0; mi[1]++;
            if (mi[1] == 60) begin
                mi[1] = 0; mi[2]++;
                if (mi[2] == 24) begin
                    mi[2] = 0;
                    mi[3] = (mi[3] == 7) ? 1 : mi[3] + 1;
                    mi[4]++;
                    if (mi[4] > dim(mi[5], mi[6])) begin
                        mi[4] = 1; mi[5]++;
                        if (mi[5] == 13) begin
                            mi[5] = 1;
                            mi[6] = (mi[6] == 99) ? 0 : mi[6] + 1;
                        end
                    end
                end
            end
        end
        if (te_m) mu = mi;
    endtask

    task automatic model_write(input int a, input logic [7:0] d);
        if (a < 7) begin
            mi[a] = from_bcd(d);
            mu[a] = mi[a];
        end else begin
            te_m = d[0];
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_tick();
    endtask

    task automatic tick_and_write(input int a, input logic [7:0] d);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = 3'(a); wr_data = d;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        model_tick();
        model_write(a, d);
    endtask

    task automatic chk(input string tag, input int a, input int exp);
        @(negedge clk);
        addr = 3'(a);
        #1;
        total++;
        if (rd_data !== 8'(exp)) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rd_data, 8'(exp));
        end
    endtask

    task automatic check_user(input string tag);
        for (int i = 0; i < 7; i++) chk(tag, i, to_bcd(mu[i]));
    endtask

    task automatic set_time(input int s, input int m, input int h, input int w,
                            input int dd, input int mo, input int y);
        wr(0, 8'(to_bcd(s))); wr(1, 8'(to_bcd(m))); wr(2, 8'(to_bcd(h)));
        wr(3, 8'(to_bcd(w))); wr(4, 8'(to_bcd(dd))); wr(5, 8'(to_bcd(mo)));
        wr(6, 8'(to_bcd(y)));
    endtask

    initial begin
        mi = '{0, 0, 0, 1, 1, 1, 0};
        mu = mi;
        te_m = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 and R7: reset values and control register
        check_user("R1");
        chk("R7", 7, 8'h01);

        // R2: second and minute BCD carries over 200 ticks
        for (int k = 0; k < 200; k++) begin
            do_tick();
            chk("R2", 0, to_bcd(mu[0]));
            chk("R2", 1, to_bcd(mu[1]));
        end

        // R3 and R4: midnight with weekday wrap, then a normal weekday step
        set_time(58, 59, 23, 7, 10, 3, 23);
        for (int k = 0; k < 3; k++) begin
            do_tick();
            check_user("R3");
        end
        set_time(59, 59, 23, 3, 10, 3, 23);
        do_tick();
        check_user("R4");

        // R5: February end for every year 00..99
        for (int y = 0; y < 100; y++) begin
            set_time(59, 59, 23, 2, 28, 2, y);
            do_tick();
            check_user("R5");
        end

        // R5 and R6: last day of each month, year 23 and year 99
        for (int mo = 1; mo <= 12; mo++) begin
            set_time(59, 59, 23, 5, dim(mo, 23), mo, 23);
            do_tick();
            check_user("R5");
        end
        set_time(59, 59, 23, 6, 31, 12, 99);
        do_tick();
        check_user("R6");

        // R8: freeze, internal still counts
        set_time(50, 59, 23, 1, 30, 6, 45);
        wr(7, 8'h00);
        chk("R7", 7, 8'h00);
        for (int k = 0; k < 15; k++) do_tick();
        check_user("R8");

        // R10: write while frozen lands in the user copy only for that field
        wr(1, 8'h42);
        check_user("R10");

        // R9: re-enable, still frozen until a tick, then caught up
        wr(7, 8'h01);
        check_user("R9");
        do_tick();
        check_user("R9");

        // R11: write and tick in the same cycle, enabled
        set_time(59, 12, 5, 2, 14, 8, 30);
        tick_and_write(0, 8'h10);
        check_user("R11");
        // R11: collision while frozen
        wr(7, 8'h00);
        set_time(59, 59, 23, 4, 31, 12, 99);
        tick_and_write(2, 8'h07);
        check_user("R11");
        wr(7, 8'h01);
        do_tick();
        check_user("R11");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule